// File: doc/BRIEF.md
# Three-Level PWM Command Decoder with Preliminary Over-Voltage Latch

This block sits in front of a half-bridge gate sequencer. It receives a PWM signal that can take three levels, already reduced to two comparator flags: one set when the input is above the upper threshold, one set when it is below the lower threshold. It turns these into a registered command for the sequencer: drive the high-side switch, drive the low-side switch, or keep both switches off. A mid-level input is taken as an off request only after it has lasted for a programmable hold-off count. Until then the last valid command stays in force. Once the decoder is off, only a clean low level brings it back.

The block also applies the supply and enable rules. While the supply-good flag is low, or while enable is low, the command is off at once. The gate path adds no clock delay. After the supply becomes good, the decoder starts in the off state with a protection armed. While the decoder is off, a switch-node over-threshold flag sets a latch that forces the low-side switch on. This protects the load if the high-side switch has failed. The first exit from the off state clears the latch and disarms the protection until the supply drops again.

Top module: `tristate_pwm_ctrl`

## Requirements
- R1: While `uvlo_ok_i` is low, `cmd_o` is 2'b00 (both off) and `force_ls_o` is 0 in the same cycle, whatever the other inputs are.
- R2: While `en_i` is low, `cmd_o` is 2'b00 in the same cycle. From the next edge on, the decoder is in the off state.
- R3: Command encoding is 2'b00 off, 2'b01 low side, 2'b10 high side, and 2'b11 never appears. A level with only `pwm_hi_i` set is HIGH, and a level with only `pwm_lo_i` set is LOW. A level with neither flag set, or with both set, is MID. A HIGH or LOW level sampled at a clock edge is shown on `cmd_o` right after that edge.
- R4: With the decoder active, a MID level that lasts for HOLD_CYC consecutive sampled edges (default 15) switches the command to off at the HOLD_CYC-th edge. For fewer edges, the previous command is kept. Any HIGH or LOW sample restarts the count.
- R5: In the off state, a HIGH level does not leave off. Only a LOW level does, and then the command becomes low side.
- R6: After `uvlo_ok_i` rises, the decoder starts in the off state.
- R7: While the protection is armed and the decoder is off (or `en_i` is low), `sw_ovp_i` high at an edge sets `force_ls_o` after that edge. It stays set after `sw_ovp_i` falls.
- R8: Exiting the off state on a LOW level clears `force_ls_o` at the same edge, and the command becomes low side.
- R9: After the first exit from the off state, `sw_ovp_i` has no effect until `uvlo_ok_i` has been low. A later rise of `uvlo_ok_i` arms the protection again.
- R10: `force_ls_o` is high only while `uvlo_ok_i` is high. It drops in the same cycle that `uvlo_ok_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_ok_i | input | 1 | Supply above the undervoltage threshold |
| en_i | input | 1 | Enable |
| pwm_hi_i | input | 1 | PWM above the upper threshold |
| pwm_lo_i | input | 1 | PWM below the lower threshold |
| sw_ovp_i | input | 1 | Switch node above the over-voltage warning level |
| cmd_o | output | 2 | Gate sequencer command (00 off, 01 low side, 10 high side) |
| force_ls_o | output | 1 | Override: force the low-side switch on |

## Verification
On every cycle, the assertions check the combinational gating by supply and enable, the absence of the unused command code, and that the override needs a good supply. They also check that the latch holds until a low-level exit, that the exit clears it, and that a HIGH level cannot leave the off state. Only the bench scenarios can show the exact hold-off boundary (HOLD_CYC-1 against HOLD_CYC MID edges) and the count restart. The same holds for the one-shot disarm of the protection after the first exit, and its re-arming after a supply drop.

// File: rtl/tristate_pwm_pkg.sv
// Shared types for the three-level PWM decoder.
// Assumes: the command encoding is decoded by the gate sequencer, so its values are fixed.
package tristate_pwm_pkg;

    typedef enum logic [1:0] {
        CMD_OFF  = 2'b00,
        CMD_LOW  = 2'b01,
        CMD_HIGH = 2'b10
    } gate_cmd_e;

    typedef enum logic [1:0] {
        LVL_MID  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10
    } pwm_level_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10
    } mode_state_e;

endpackage

// File: rtl/tristate_pwm_level.sv
// Classifies the two comparator flags into one of three PWM levels.
// Assumes: the flags are already synchronous to clk; exactly one flag set is a valid level,
// and neither or both set is treated as the mid band.
module tristate_pwm_level
    import tristate_pwm_pkg::*;
(
    input  logic       above_i,
    input  logic       below_i,
    output pwm_level_e level_o
);

    // Purpose: map the flag pair to a level.
    always_comb begin
        unique case ({above_i, below_i})
            2'b10:   level_o = LVL_HIGH;
            2'b01:   level_o = LVL_LOW;
            default: level_o = LVL_MID;
        endcase
    end

endmodule

// File: rtl/tristate_pwm_holdoff.sv
// Counts consecutive mid-band samples while the decoder is active.
// Raises expire_o on the sample that completes HOLD_CYC of them.
// Assumes: HOLD_CYC >= 1; run_i low or a valid level clears the count.
module tristate_pwm_holdoff #(
    parameter int HOLD_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic mid_i,
    output logic expire_o
);

    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: flag the sample that completes the hold-off window.
    always_comb begin
        expire_o = run_i && mid_i && (cnt_q == LAST);
    end

    // Purpose: advance or restart the mid-band counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || !mid_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tristate_pwm_mode.sv
// Mode register: off, low side or high side.
// Supply or enable loss forces off. The off state is left only on a low level.
// Hold-off expiry moves an active mode to off.
// Assumes: level_i and expire_i are sampled at the same edge.
module tristate_pwm_mode
    import tristate_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        uvlo_ok_i,
    input  logic        en_i,
    input  pwm_level_e  level_i,
    input  logic        expire_i,
    output mode_state_e state_o,
    output logic        exit_off_o
);

    mode_state_e state_q, state_d;

    // Purpose: next-state decision.
    always_comb begin
        state_d = state_q;
        if (!uvlo_ok_i || !en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (level_i == LVL_LOW) state_d = ST_LOW;
                end
                default: begin
                    if (level_i == LVL_LOW)       state_d = ST_LOW;
                    else if (level_i == LVL_HIGH) state_d = ST_HIGH;
                    else if (expire_i)            state_d = ST_OFF;
                end
            endcase
        end
    end

    // Purpose: mark the edge on which the off state is left.
    always_comb begin
        exit_off_o = (state_q == ST_OFF) && (state_d != ST_OFF);
    end

    // Purpose: hold the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/tristate_pwm_ovp.sv
// Preliminary over-voltage latch.
// Armed while the supply is not good; disarmed by the first exit from off.
// While armed and off, a switch-node over-threshold sets the latch.
// Assumes: exit_i is a single-edge pulse from the mode register.
module tristate_pwm_ovp (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo_ok_i,
    input  logic off_i,
    input  logic exit_i,
    input  logic sw_ovp_i,
    output logic force_ls_o
);

    logic armed_q;
    logic latch_q;

    // Purpose: arm, set and clear the protection latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !uvlo_ok_i) begin
            armed_q <= 1'b1;
            latch_q <= 1'b0;
        end else if (exit_i) begin
            armed_q <= 1'b0;
            latch_q <= 1'b0;
        end else if (armed_q && off_i && sw_ovp_i) begin
            latch_q <= 1'b1;
        end
    end

    // Purpose: the override needs a good supply, with no delay.
    always_comb begin
        force_ls_o = latch_q && uvlo_ok_i;
    end

endmodule

// File: rtl/tristate_pwm_ctrl.sv
// Top: three-level PWM decoder with supply/enable gating and a low-side override.
// Assumes: all inputs synchronous to clk; HOLD_CYC is the hold-off time in cycles.
module tristate_pwm_ctrl
    import tristate_pwm_pkg::*;
#(
    parameter int HOLD_CYC = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo_ok_i,
    input  logic       en_i,
    input  logic       pwm_hi_i,
    input  logic       pwm_lo_i,
    input  logic       sw_ovp_i,
    output logic [1:0] cmd_o,
    output logic       force_ls_o
);

    pwm_level_e  level;
    mode_state_e state;
    logic        expire;
    logic        exit_off;
    logic        run;

    tristate_pwm_level u_level (
        .above_i (pwm_hi_i),
        .below_i (pwm_lo_i),
        .level_o (level)
    );

    // Purpose: the hold-off counter runs only in an active mode.
    always_comb begin
        run = uvlo_ok_i && en_i && (state != ST_OFF);
    end

    tristate_pwm_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .mid_i    (level == LVL_MID),
        .expire_o (expire)
    );

    tristate_pwm_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .uvlo_ok_i  (uvlo_ok_i),
        .en_i       (en_i),
        .level_i    (level),
        .expire_i   (expire),
        .state_o    (state),
        .exit_off_o (exit_off)
    );

    tristate_pwm_ovp u_ovp (
        .clk        (clk),
        .rst_n      (rst_n),
        .uvlo_ok_i  (uvlo_ok_i),
        .off_i      ((state == ST_OFF) || !en_i),
        .exit_i     (exit_off),
        .sw_ovp_i   (sw_ovp_i),
        .force_ls_o (force_ls_o)
    );

    // Purpose: gate the registered mode by supply and enable without delay.
    always_comb begin
        if (!uvlo_ok_i || !en_i) begin
            cmd_o = CMD_OFF;
        end else begin
            unique case (state)
                ST_LOW:  cmd_o = CMD_LOW;
                ST_HIGH: cmd_o = CMD_HIGH;
                default: cmd_o = CMD_OFF;
            endcase
        end
    end

endmodule

// Checker for tristate_pwm_ctrl, attached through bind.
module tristate_pwm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uvlo_ok_i,
    input logic       en_i,
    input logic       pwm_hi_i,
    input logic       pwm_lo_i,
    input logic [1:0] cmd_o,
    input logic       force_ls_o
);

    // R1
    uvlo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok_i |-> (cmd_o == 2'b00 && !force_ls_o));

    // R2
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> cmd_o == 2'b00);

    // R3
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != 2'b11);

    // R5
    off_high_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b00 && uvlo_ok_i && en_i && pwm_hi_i && !pwm_lo_i) |=> cmd_o == 2'b00);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ls_o && !(en_i && pwm_lo_i && !pwm_hi_i)) |=> (force_ls_o || !uvlo_ok_i));

    // R8
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ls_o && en_i && pwm_lo_i && !pwm_hi_i) |=> !force_ls_o);

    // R10
    force_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_ls_o |-> uvlo_ok_i);

endmodule

bind tristate_pwm_ctrl tristate_pwm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uvlo_ok_i  (uvlo_ok_i),
    .en_i       (en_i),
    .pwm_hi_i   (pwm_hi_i),
    .pwm_lo_i   (pwm_lo_i),
    .cmd_o      (cmd_o),
    .force_ls_o (force_ls_o)
);

// File: tb/tristate_pwm_ctrl_tb_top.sv
// Directed bench for tristate_pwm_ctrl. Inputs change on falling edges and outputs are read there.
module tristate_pwm_ctrl_tb_top;

    localparam int HOLD = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uvlo_ok = 1'b0;
    logic       en = 1'b0;
    logic       hi = 1'b0;
    logic       lo = 1'b0;
    logic       ovp = 1'b0;
    logic [1:0] cmd;
    logic       force_ls;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tristate_pwm_ctrl #(.HOLD_CYC(HOLD)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .uvlo_ok_i  (uvlo_ok),
        .en_i       (en),
        .pwm_hi_i   (hi),
        .pwm_lo_i   (lo),
        .sw_ovp_i   (ovp),
        .cmd_o      (cmd),
        .force_ls_o (force_ls)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lvl(input logic h, input logic l);
        hi = h;
        lo = l;
    endtask

    task automatic chk(input string req, input logic [1:0] act_cmd, input logic [1:0] exp_cmd,
                       input logic act_f, input logic exp_f);
        n_chk++;
        if (act_cmd !== exp_cmd || act_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: cmd=%b force=%b expected cmd=%b force=%b",
                     req, act_cmd, act_f, exp_cmd, exp_f);
        end
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 reset", cmd, 2'b00, force_ls, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_supply_gate();
        en = 1'b1; lvl(1, 0); ovp = 1'b1;
        step(3);
        chk("R1 supply low, PWM high", cmd, 2'b00, force_ls, 1'b0);
        chk("R10 supply low, ovp high", cmd, 2'b00, force_ls, 1'b0);
        ovp = 1'b0;
    endtask

    task automatic t_startup_ovp();
        uvlo_ok = 1'b1; lvl(0, 0);
        step(2);
        chk("R6 start in off", cmd, 2'b00, force_ls, 1'b0);
        lvl(1, 0);
        step(2);
        chk("R5 high does not leave off", cmd, 2'b00, force_ls, 1'b0);
        ovp = 1'b1;
        step(1);
        chk("R7 latch set", cmd, 2'b00, force_ls, 1'b1);
        ovp = 1'b0;
        step(3);
        chk("R7 latch held", cmd, 2'b00, force_ls, 1'b1);
        lvl(0, 1);
        step(1);
        chk("R8 exit clears latch", cmd, 2'b01, force_ls, 1'b0);
    endtask

    task automatic t_disarm();
        lvl(1, 0);
        step(1);
        chk("R3 high level", cmd, 2'b10, force_ls, 1'b0);
        lvl(0, 0);
        step(HOLD);
        chk("R4 full hold-off to off", cmd, 2'b00, force_ls, 1'b0);
        ovp = 1'b1;
        step(2);
        chk("R9 disarmed after exit", cmd, 2'b00, force_ls, 1'b0);
        ovp = 1'b0;
        lvl(0, 1);
        step(1);
        chk("R3 low level", cmd, 2'b01, force_ls, 1'b0);
    endtask

    task automatic t_holdoff();
        lvl(1, 0);
        step(1);
        lvl(0, 0);
        step(HOLD - 1);
        chk("R4 one short keeps high", cmd, 2'b10, force_ls, 1'b0);
        step(1);
        chk("R4 boundary reaches off", cmd, 2'b00, force_ls, 1'b0);
        lvl(0, 1);
        step(1);
        lvl(0, 0);
        step(10);
        lvl(1, 0);
        step(1);
        chk("R3 high after partial mid", cmd, 2'b10, force_ls, 1'b0);
        lvl(0, 0);
        step(HOLD - 1);
        chk("R4 count restarted", cmd, 2'b10, force_ls, 1'b0);
        step(1);
        chk("R4 restarted window ends", cmd, 2'b00, force_ls, 1'b0);
        lvl(0, 1);
        step(1);
        lvl(1, 1);
        step(HOLD - 1);
        chk("R3 both flags mid, held", cmd, 2'b01, force_ls, 1'b0);
        step(1);
        chk("R3 both flags mid, off", cmd, 2'b00, force_ls, 1'b0);
    endtask

    task automatic t_enable();
        lvl(0, 1);
        step(1);
        en = 1'b0;
        #1;
        chk("R2 enable low same cycle", cmd, 2'b00, force_ls, 1'b0);
        lvl(1, 0);
        step(2);
        chk("R2 enable low ignores PWM", cmd, 2'b00, force_ls, 1'b0);
        en = 1'b1;
        step(2);
        chk("R2 re-enable needs low", cmd, 2'b00, force_ls, 1'b0);
        lvl(0, 1);
        step(1);
        chk("R5 low leaves off", cmd, 2'b01, force_ls, 1'b0);
    endtask

    task automatic t_rearm();
        uvlo_ok = 1'b0;
        step(1);
        chk("R1 supply drop", cmd, 2'b00, force_ls, 1'b0);
        uvlo_ok = 1'b1; lvl(0, 0); ovp = 1'b1;
        step(2);
        chk("R9 re-armed after supply cycle", cmd, 2'b00, force_ls, 1'b1);
        ovp = 1'b0;
        uvlo_ok = 1'b0;
        #1;
        chk("R10 force drops with supply", cmd, 2'b00, force_ls, 1'b0);
    endtask

    initial begin
        t_reset();
        t_supply_gate();
        t_startup_ovp();
        t_disarm();
        t_holdoff();
        t_enable();
        t_rearm();
        step(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule